// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

The block is a memory-mapped general-purpose I/O controller for sixteen pins. Software reaches it through a plain 32-bit register port with a write strobe and a read strobe. Each pin has its own bits for input enable, output enable, output value and output inversion. The pad output is the stored value with the inversion mask applied, and the pad enable follows the output-enable bit. Pad inputs pass through a two-stage synchroniser before the block uses them.

Every pin can raise four kinds of event: a rising edge, a falling edge, a high level and a low level. Each kind has its own enable register and its own sticky pending register, which software clears by writing ones. Each pin drives its own interrupt line, which is high while that pin has a pending event whose enable bit is set. The pull-up, drive-strength, alternate-enable and alternate-select registers only store values for logic outside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and pad_out, pad_oe and irq are all 0.
- R2: Register offsets are: input value 0x00, input enable 0x04, output enable 0x08, output value 0x0C, pull-up 0x10, drive strength 0x14, rise enable/pending 0x18/0x1C, fall enable/pending 0x20/0x24, high enable/pending 0x28/0x2C, low enable/pending 0x30/0x34, alternate enable 0x38, alternate select 0x3C, output invert 0x40. Pin n uses bit n. A read strobe returns its data on bus_rdata one cycle later. Unmapped offsets and bits 31:16 read 0. Writes to the input value register are ignored.
- R3: The pull-up, drive-strength, alternate-enable and alternate-select registers store bits 15:0 of the written word and have no other effect.
- R4: pad_out equals output value XOR output invert, and pad_oe equals output enable. Both take a new value in the cycle after the write.
- R5: The input value register shows the pad level after two synchroniser flops, ANDed with input enable. A pin whose input enable is clear reads 0.
- R6: On a pin with input enable set, a 0-to-1 change of the synchronised level sets that pin's rise pending bit, and a 1-to-0 change sets its fall pending bit. This happens whatever the trigger enables hold.
- R7: On a pin with input enable set, the high (low) pending bit is set in every cycle that the synchronised level is 1 (0). If the level is still present when software clears the bit, it reads as set again.
- R8: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. If a new event for that bit arrives in the same cycle as the clear, the bit stays set.
- R9: irq[n] is 1 exactly while some trigger kind has both its pending bit n and its enable bit n set.
- R10: A pin whose input enable is clear raises no pending bit, whatever its pad does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| irq | output | 16 | One interrupt line per pin |

## Verification
Two things can happen to a pending bit in the same clock: a software clear and a new trigger condition for that bit. The bench produces a rise on one pin and times the pad change, counting the synchroniser stages, so that the edge reaches the pending logic in the same cycle as a write-one-to-clear. That write also covers another pin that was already pending. Reading the register back must show the already-pending pin cleared and the pin whose edge coincided with the clear still set. Clearing a level-pending bit while its level is held is the second case where the two meet.

// File: rtl/gpio_irq_pkg.sv
// Package: constants and types shared by the GPIO controller modules.
// Assumes byte offsets on an 8-bit register address and 32-bit data.
package gpio_irq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int NTRIG  = 4;

    // Trigger kinds. The order sets where each kind sits in the address map.
    typedef enum logic [1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;

    localparam logic [ADDR_W-1:0] A_IN     = 8'h00;
    localparam logic [ADDR_W-1:0] A_INEN   = 8'h04;
    localparam logic [ADDR_W-1:0] A_OE     = 8'h08;
    localparam logic [ADDR_W-1:0] A_OUT    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_PULL   = 8'h10;
    localparam logic [ADDR_W-1:0] A_DRV    = 8'h14;
    localparam logic [ADDR_W-1:0] A_TRIG0  = 8'h18;
    localparam logic [ADDR_W-1:0] A_ALTEN  = 8'h38;
    localparam logic [ADDR_W-1:0] A_ALTSEL = 8'h3C;
    localparam logic [ADDR_W-1:0] A_FLIP   = 8'h40;

    // Enable register offset of trigger kind t.
    function automatic logic [ADDR_W-1:0] trig_en_addr(input int t);
        return A_TRIG0 + ADDR_W'(8 * t);
    endfunction

    // Pending register offset of trigger kind t.
    function automatic logic [ADDR_W-1:0] trig_pend_addr(input int t);
        return A_TRIG0 + ADDR_W'(8 * t + 4);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: input synchroniser and trigger-condition detector.
// Two flops take the pad levels into the clock domain. A third flop holds
// the previous synchronised level so that edges can be found. Every
// condition is gated by the pin's input enable. Assumes pad_in is
// asynchronous and changes slowly compared with the clock.
module gpio_in_sync
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPINS-1:0]             pad_in,
    input  logic [NPINS-1:0]             in_en,
    output logic [NPINS-1:0]             in_level,
    output logic [NTRIG-1:0][NPINS-1:0]  cond
);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;

    // Synchroniser chain plus the previous-level history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Level seen by software: synchronised level of enabled pins only.
    assign in_level = sync_q & in_en;

    // Per-kind trigger conditions, valid for enabled pins only.
    always_comb begin
        cond[TRIG_RISE] =  sync_q & ~prev_q & in_en;
        cond[TRIG_FALL] = ~sync_q &  prev_q & in_en;
        cond[TRIG_HIGH] =  sync_q & in_en;
        cond[TRIG_LOW]  = ~sync_q & in_en;
    end

endmodule

// File: rtl/gpio_trig_bank.sv
// Module: trigger enable and pending registers for the four trigger kinds.
// One register pair per kind is generated. A pending bit is set by its
// condition and cleared by a write of one, and the condition wins when both
// come in the same cycle. Interrupt n is the OR over kinds of pending AND
// enable. Assumes the write strobe lasts one cycle for each access.
module gpio_trig_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_stb,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [NPINS-1:0]             wr_bits,
    input  logic [NTRIG-1:0][NPINS-1:0]  cond,
    output logic [NTRIG-1:0][NPINS-1:0]  en_q,
    output logic [NTRIG-1:0][NPINS-1:0]  pend_q,
    output logic [NPINS-1:0]             irq
);

    for (genvar t = 0; t < NTRIG; t++) begin : g_kind
        localparam logic [ADDR_W-1:0] EN_A = trig_en_addr(t);
        localparam logic [ADDR_W-1:0] PD_A = trig_pend_addr(t);

        logic [NPINS-1:0] en_r;
        logic [NPINS-1:0] pend_r;
        logic [NPINS-1:0] clr;

        // Mask of pending bits cleared by this cycle's write.
        assign clr = (wr_stb && wr_addr == PD_A) ? wr_bits : '0;

        // Enable register of this kind: plain read/write storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_r <= '0;
            else if (wr_stb && wr_addr == EN_A)
                en_r <= wr_bits;
        end

        // Sticky pending register: the condition sets it, a write of one clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_r <= '0;
            else
                pend_r <= (pend_r & ~clr) | cond[t];
        end

        assign en_q[t]   = en_r;
        assign pend_q[t] = pend_r;
    end

    // Per-pin interrupt: any kind that is both pending and enabled.
    always_comb begin
        irq = '0;
        for (int t = 0; t < NTRIG; t++)
            irq = irq | (pend_q[t] & en_q[t]);
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: per-pin configuration storage and pad output drive.
// Holds the direction, output value, inversion mask and the storage-only
// pad registers. Pad output is value XOR inversion. The pad enable is the
// output-enable register itself. Assumes a single write port.
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_bits,
    output logic [NPINS-1:0]  in_en_q,
    output logic [NPINS-1:0]  oe_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  flip_q,
    output logic [NPINS-1:0]  pull_q,
    output logic [NPINS-1:0]  drv_q,
    output logic [NPINS-1:0]  alt_en_q,
    output logic [NPINS-1:0]  alt_sel_q,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    // Address-decoded write into the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_en_q   <= '0;
            oe_q      <= '0;
            out_q     <= '0;
            flip_q    <= '0;
            pull_q    <= '0;
            drv_q     <= '0;
            alt_en_q  <= '0;
            alt_sel_q <= '0;
        end else if (wr_stb) begin
            case (wr_addr)
                A_INEN:   in_en_q   <= wr_bits;
                A_OE:     oe_q      <= wr_bits;
                A_OUT:    out_q     <= wr_bits;
                A_FLIP:   flip_q    <= wr_bits;
                A_PULL:   pull_q    <= wr_bits;
                A_DRV:    drv_q     <= wr_bits;
                A_ALTEN:  alt_en_q  <= wr_bits;
                A_ALTSEL: alt_sel_q <= wr_bits;
                default:  ;
            endcase
        end
    end

    // Pad drive: inverted value and direct enable.
    assign pad_out = out_q ^ flip_q;
    assign pad_oe  = oe_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO controller with per-pin interrupts.
// Connects the configuration registers, the input synchroniser and the
// trigger bank, and registers the read data one cycle after a read strobe.
// Assumes NPINS is below 32. Register bits above NPINS read as zero.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  irq
);

    logic [NPINS-1:0]             wr_bits;
    logic                         unused_wdata_hi;
    logic [NPINS-1:0]             in_en_q, oe_q, out_q, flip_q;
    logic [NPINS-1:0]             pull_q, drv_q, alt_en_q, alt_sel_q;
    logic [NPINS-1:0]             in_level;
    logic [NTRIG-1:0][NPINS-1:0]  trig_cond;
    logic [NTRIG-1:0][NPINS-1:0]  trig_en_q;
    logic [NTRIG-1:0][NPINS-1:0]  trig_pend_q;
    logic [NPINS-1:0]             rd_sel;
    logic [REG_W-1:0]             rd_mux;

    assign wr_bits         = bus_wdata[NPINS-1:0];
    assign unused_wdata_hi = ^bus_wdata[REG_W-1:NPINS];

    gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (bus_wr),
        .wr_addr   (bus_addr),
        .wr_bits   (wr_bits),
        .in_en_q   (in_en_q),
        .oe_q      (oe_q),
        .out_q     (out_q),
        .flip_q    (flip_q),
        .pull_q    (pull_q),
        .drv_q     (drv_q),
        .alt_en_q  (alt_en_q),
        .alt_sel_q (alt_sel_q),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .in_en    (in_en_q),
        .in_level (in_level),
        .cond     (trig_cond)
    );

    gpio_trig_bank #(.NPINS(NPINS)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (bus_wr),
        .wr_addr (bus_addr),
        .wr_bits (wr_bits),
        .cond    (trig_cond),
        .en_q    (trig_en_q),
        .pend_q  (trig_pend_q),
        .irq     (irq)
    );

    // Read-data select by offset. Unmapped offsets give zero.
    always_comb begin
        rd_sel = '0;
        case (bus_addr)
            A_IN:     rd_sel = in_level;
            A_INEN:   rd_sel = in_en_q;
            A_OE:     rd_sel = oe_q;
            A_OUT:    rd_sel = out_q;
            A_FLIP:   rd_sel = flip_q;
            A_PULL:   rd_sel = pull_q;
            A_DRV:    rd_sel = drv_q;
            A_ALTEN:  rd_sel = alt_en_q;
            A_ALTSEL: rd_sel = alt_sel_q;
            default:  ;
        endcase
        for (int t = 0; t < NTRIG; t++) begin
            if (bus_addr == trig_en_addr(t))   rd_sel = trig_en_q[t];
            if (bus_addr == trig_pend_addr(t)) rd_sel = trig_pend_q[t];
        end
        rd_mux = '0;
        rd_mux[NPINS-1:0] = rd_sel;
    end

    // Read-data register, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: assertion checker bound to the GPIO controller top.
// Watches the ports and the internal trigger and enable state over time.
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [7:0]                   bus_addr,
    input logic [31:0]                  bus_wdata,
    input logic [31:0]                  bus_rdata,
    input logic [NPINS-1:0]             pad_out,
    input logic [NPINS-1:0]             pad_oe,
    input logic [NPINS-1:0]             irq,
    input logic [NPINS-1:0]             in_en,
    input logic [NTRIG-1:0][NPINS-1:0]  trig_en,
    input logic [NTRIG-1:0][NPINS-1:0]  trig_pend,
    input logic [NTRIG-1:0][NPINS-1:0]  trig_cond
);

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_OE) |=> $stable(pad_oe));

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_OUT || bus_addr == A_FLIP)) |=> $stable(pad_out));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en == '0 && !bus_wr) |=> (irq == '0));

    // R5
    inval_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_IN) |=>
            ((bus_rdata[NPINS-1:0] & ~$past(in_en)) == '0) && (bus_rdata[31:NPINS] == '0));

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == trig_pend_addr(0) && bus_wdata[NPINS-1:0] == '1
         && trig_cond[TRIG_RISE] == '0) |=> (trig_pend[TRIG_RISE] == '0));

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cond[TRIG_FALL] == '0) |=>
            ((trig_pend[TRIG_FALL] & ~$past(trig_pend[TRIG_FALL])) == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .in_en     (in_en_q),
    .trig_en   (trig_en_q),
    .trig_pend (trig_pend_q),
    .trig_cond (trig_cond)
);

// File: tb/gpio_irq_ctrl_bench.sv
// Scoreboard bench: the read driver queues expected words, and a monitor
// pops and compares them when the registered read data appears.
module gpio_irq_ctrl_bench;
    import gpio_irq_pkg::*;

    localparam int NP = 16;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] irq;

    item_t exp_q[$];
    logic  rd_seen = 1'b0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;

    gpio_irq_ctrl #(.NPINS(NP)) u_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    always #2ns clk = ~clk;

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Remember that a read was sampled at this edge.
    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare the registered read data with the queued expectation.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R2: read data with no expectation, got %h expected none", bus_rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4ns);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1: reset state of outputs and every register
        check(32'(pad_out), 0, "R1 pad_out");
        check(32'(pad_oe), 0, "R1 pad_oe");
        check(32'(irq), 0, "R1 irq");
        for (int a = 0; a <= 16; a++) rd(8'(a * 4), 0, "R1 register");
        // R2: unmapped offsets
        rd(8'h44, 0, "R2 unmapped");
        rd(8'h80, 0, "R2 unmapped");

        // R4: output value, inversion and enable
        wr(A_OUT, 32'h0000_00A5);
        wr(A_OE, 32'h0000_00FF);
        check(32'(pad_out), 32'h00A5, "R4 pad_out");
        check(32'(pad_oe), 32'h00FF, "R4 pad_oe");
        wr(A_FLIP, 32'h0000_000F);
        check(32'(pad_out), 32'h00AA, "R4 pad_out inverted");
        rd(A_FLIP, 32'h000F, "R4 invert readback");

        // R3: storage-only registers, upper bits dropped
        wr(A_PULL, 32'h0000_1234);
        rd(A_PULL, 32'h1234, "R3 pull");
        wr(A_ALTSEL, 32'hFFFF_FFFF);
        rd(A_ALTSEL, 32'h0000_FFFF, "R3 alt select width");
        check(32'(pad_out), 32'h00AA, "R3 no effect on pad_out");

        // R5/R10: disabled input reads zero and raises nothing
        pad_in = 16'h5A5A;
        idle(4);
        rd(A_IN, 0, "R5 disabled input");
        rd(trig_pend_addr(TRIG_HIGH), 0, "R10 disabled high");
        wr(A_INEN, 32'h0000_00FF);
        idle(3);
        rd(A_IN, 32'h005A, "R5 enabled input");
        wr(A_IN, 32'h0000_FFFF);
        rd(A_IN, 32'h005A, "R2 input value write ignored");
        rd(trig_pend_addr(TRIG_HIGH), 32'h005A, "R7 high pending");
        rd(trig_pend_addr(TRIG_LOW), 32'h00A5, "R7 low pending");
        rd(trig_pend_addr(TRIG_RISE), 0, "R6 no rise on enable");
        // R7: clear while the level persists
        wr(trig_pend_addr(TRIG_LOW), 32'h0000_FFFF);
        rd(trig_pend_addr(TRIG_LOW), 32'h00A5, "R7 low re-set");

        // R6: rising edges
        pad_in = 16'h00FF;
        idle(4);
        rd(trig_pend_addr(TRIG_RISE), 32'h00A5, "R6 rise pending");
        rd(trig_pend_addr(TRIG_FALL), 0, "R6 no fall");
        wr(trig_pend_addr(TRIG_LOW), 32'h0000_FFFF);
        rd(trig_pend_addr(TRIG_LOW), 0, "R8 low cleared");
        // R8: partial clear
        wr(trig_pend_addr(TRIG_RISE), 32'h0000_0005);
        rd(trig_pend_addr(TRIG_RISE), 32'h00A0, "R8 zero bits keep");

        // R9: interrupt lines
        check(32'(irq), 0, "R9 pending without enable");
        wr(trig_en_addr(TRIG_RISE), 32'h0000_0080);
        check(32'(irq), 32'h0080, "R9 rise irq");
        wr(trig_pend_addr(TRIG_RISE), 32'h0000_00A0);
        check(32'(irq), 0, "R9 irq after clear");

        // R6/R10: falling edges, disabled upper pins toggled
        pad_in = 16'hFF0F;
        idle(4);
        rd(trig_pend_addr(TRIG_FALL), 32'h00F0, "R6 fall pending");
        rd(trig_pend_addr(TRIG_RISE), 0, "R10 disabled pins no rise");
        for (int t = 0; t < NTRIG; t++) wr(trig_pend_addr(t), 32'h0000_FFFF);
        rd(trig_pend_addr(TRIG_HIGH), 32'h000F, "R7 high persists");
        rd(trig_pend_addr(TRIG_LOW), 32'h00F0, "R7 low persists");
        wr(trig_en_addr(TRIG_HIGH), 32'h0000_0001);
        check(32'(irq), 32'h0001, "R9 high irq");
        wr(trig_en_addr(TRIG_LOW), 32'h0000_0010);
        check(32'(irq), 32'h0011, "R9 two kinds");
        wr(trig_en_addr(TRIG_HIGH), 0);
        wr(trig_en_addr(TRIG_LOW), 0);
        check(32'(irq), 0, "R9 enables off");

        // R8: clear and new edge in the same cycle
        idle(1);
        pad_in = 16'hFF1F;
        idle(4);
        rd(trig_pend_addr(TRIG_RISE), 32'h0010, "R6 pin4 rise");
        idle(1);
        pad_in = 16'hFF3F;
        @(negedge clk);
        wr(trig_pend_addr(TRIG_RISE), 32'h0000_0030);
        rd(trig_pend_addr(TRIG_RISE), 32'h0020, "R8 set wins over clear");
        wr(trig_en_addr(TRIG_RISE), 32'h0000_0020);
        check(32'(irq), 32'h0020, "R9 irq after collision");

        // R5: two-flop latency on the input value
        idle(1);
        pad_in = 16'hFF7F;
        rd(A_IN, 32'h003F, "R5 not yet visible");
        idle(2);
        rd(A_IN, 32'h007F, "R5 visible after sync");

        idle(3);
        if (exp_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule